// File: doc/BRIEF.md
# Bus Transceiver Handshake Controller

This controller sits between a system bus and a local peripheral and sequences each transfer through a bidirectional data transceiver. It watches a bus read strobe, a bus write strobe and the peripheral's acknowledge. It drives three outputs: a strobe to the peripheral, an enable for the transceiver and an acknowledge back to the bus.

All three inputs are asynchronous to the controller clock, so each one passes through a two-flop synchroniser. The read cycle comes from four registered next-state equations. One of them is a self-holding state bit, `hold_q`. It tells the opening phase of a read (strobe to the peripheral, waiting for data) apart from the data phase (transceiver open, bus acknowledged). Dropping the read strobe returns every output to zero.

A write cycle opens the transceiver toward the peripheral and strobes it. The peripheral's acknowledge then closes the transceiver and acknowledges the bus. If both bus strobes are seen together, the read takes precedence, the write is ignored and a protocol error flag is raised.

Top module: `xcvr_hs_ctrl`

## Requirements
- R1: While the synchronised read strobe is high, the next state bit is read AND (state bit OR NOT acknowledge), and the next peripheral strobe is transceiver enable OR state bit. From idle with acknowledge low, the peripheral strobe rises one cycle after the state bit.
- R2: While the synchronised read strobe is high, the next transceiver enable is synchronised acknowledge AND state bit. The transceiver never opens during a read while acknowledge is low.
- R3: While the synchronised read strobe is high, the next bus acknowledge equals the current transceiver enable.
- R4: If acknowledge is already high when a read begins, the state bit is never set and no output rises. Once the state bit is set, it holds through the acknowledge until the read strobe falls.
- R5: When neither synchronised strobe is high, the next strobe, enable, acknowledge and state bit are all zero. A falling read strobe therefore clears every output.
- R6: During a write (write strobe high, read strobe low), the next peripheral strobe is 1, the next enable is NOT acknowledge and the next bus acknowledge is acknowledge.
- R7: With both synchronised strobes high, the read equations govern the outputs, the write has no effect, and `proto_err` is 1 the next cycle. Otherwise `proto_err` is 0.
- R8: A synchronous active-high reset clears all outputs, the state bit and the synchronisers at the next clock edge.
- R9: An input change made between clock edges first affects a registered output at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Bus read strobe (asynchronous) |
| bus_wr | input | 1 | Bus write strobe (asynchronous) |
| dev_ack | input | 1 | Peripheral acknowledge (asynchronous) |
| dev_stb | output | 1 | Strobe to the peripheral |
| xcvr_en | output | 1 | Transceiver enable |
| bus_ack | output | 1 | Acknowledge to the bus |
| proto_err | output | 1 | Both strobes seen together |

## Verification
Two functions can land on the same edge: the read sequencing and the write sequencing. Both are triggered when the read and write strobes are raised in one cycle. The bench does this from idle with the acknowledge low. It then checks at the third edge that the transceiver stayed closed, where a write would have opened it, and that the error flag is set. At the fourth edge it checks that the peripheral strobe follows the read timing.

// File: rtl/xcvr_hs_ctrl.sv
module xcvr_hs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic dev_ack,
  output logic dev_stb,
  output logic xcvr_en,
  output logic bus_ack,
  output logic proto_err
);

  logic [2:0] meta_q, sync_q;
  logic rd_s, wr_s, ack_s;
  logic hold_q;
  logic hold_n, stb_n, en_n, back_n, err_n;

  assign rd_s  = sync_q[2];
  assign wr_s  = sync_q[1];
  assign ack_s = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {bus_rd, bus_wr, dev_ack};
      sync_q <= meta_q;
    end
  end

  always_comb begin
    hold_n = 1'b0;
    stb_n  = 1'b0;
    en_n   = 1'b0;
    back_n = 1'b0;
    if (rd_s) begin
      hold_n = hold_q | ~ack_s;
      en_n   = ack_s & hold_q;
      stb_n  = xcvr_en | hold_q;
      back_n = xcvr_en;
    end else if (wr_s) begin
      stb_n  = 1'b1;
      en_n   = ~ack_s;
      back_n = ack_s;
    end
  end

  assign err_n = rd_s & wr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      dev_stb   <= 1'b0;
      xcvr_en   <= 1'b0;
      bus_ack   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      hold_q    <= hold_n;
      dev_stb   <= stb_n;
      xcvr_en   <= en_n;
      bus_ack   <= back_n;
      proto_err <= err_n;
    end
  end

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> !dev_stb && !xcvr_en && !bus_ack && !proto_err && !hold_q);

  p_no_en_without_ack_r2: assert property (@(posedge clk) disable iff (rst)
    rd_s && !ack_s |=> !xcvr_en);

  p_ack_after_en_r3: assert property (@(posedge clk) disable iff (rst)
    rd_s && xcvr_en |=> bus_ack);

  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_s && !wr_s |=> !dev_stb && !xcvr_en && !bus_ack && !hold_q);

  p_hold_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    rd_s && hold_q |=> hold_q && dev_stb);

  p_wr_close_r6: assert property (@(posedge clk) disable iff (rst)
    wr_s && !rd_s && ack_s |=> !xcvr_en && bus_ack && dev_stb);

  p_both_flag_r7: assert property (@(posedge clk) disable iff (rst)
    rd_s && wr_s |=> proto_err);

endmodule

// File: tb/xcvr_hs_ctrl_tb_top.sv
module xcvr_hs_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, bus_rd, bus_wr, dev_ack;
  logic dev_stb, xcvr_en, bus_ack, proto_err;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xcvr_hs_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .dev_ack(dev_ack),
    .dev_stb(dev_stb), .xcvr_en(xcvr_en), .bus_ack(bus_ack), .proto_err(proto_err)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {dev_stb, xcvr_en, bus_ack, proto_err};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {stb,en,ack,err} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic go_idle();
    bus_rd = 0; bus_wr = 0; dev_ack = 0;
    edges(4);
  endtask

  task automatic t_reset();
    rst = 1; bus_rd = 0; bus_wr = 0; dev_ack = 0;
    edges(2);
    check("R8 reset state", 4'b0000);
    rst = 0;
    edges(2);
    check("R8 after release", 4'b0000);
  endtask

  task automatic t_read();
    bus_rd = 1;
    edges(3);
    check("R9 read latency, state bit only", 4'b0000);
    edges(1);
    check("R1 strobe follows state bit", 4'b1000);
    edges(3);
    check("R2 no enable without ack", 4'b1000);
    dev_ack = 1;
    edges(2);
    check("R9 ack not yet seen", 4'b1000);
    edges(1);
    check("R2 enable on ack", 4'b1100);
    edges(1);
    check("R3 bus ack follows enable", 4'b1110);
    edges(3);
    check("R4 state held through ack", 4'b1110);
    bus_rd = 0;
    edges(2);
    check("R9 read fall not yet seen", 4'b1110);
    edges(1);
    check("R5 read fall clears outputs", 4'b0000);
    go_idle();
  endtask

  task automatic t_early_ack();
    dev_ack = 1;
    edges(4);
    bus_rd = 1;
    edges(6);
    check("R4 early ack blocks read", 4'b0000);
    dev_ack = 0;
    edges(4);
    check("R1 read starts after ack drops", 4'b1000);
    go_idle();
    check("R5 idle after read", 4'b0000);
  endtask

  task automatic t_write();
    bus_wr = 1;
    edges(2);
    check("R9 write latency", 4'b0000);
    edges(1);
    check("R6 write opens and strobes", 4'b1100);
    dev_ack = 1;
    edges(3);
    check("R6 ack closes transceiver", 4'b1010);
    bus_wr = 0;
    edges(3);
    check("R5 write end clears", 4'b0000);
    go_idle();
  endtask

  task automatic t_both();
    bus_rd = 1; bus_wr = 1;
    edges(3);
    check("R7 write ignored, error flagged", 4'b0001);
    edges(1);
    check("R7 read timing governs", 4'b1001);
    bus_wr = 0;
    edges(3);
    check("R7 error clears", 4'b1000);
    go_idle();
  endtask

  task automatic t_mid_reset();
    bus_rd = 1;
    edges(6);
    rst = 1;
    edges(1);
    check("R8 reset mid read", 4'b0000);
    rst = 0; bus_rd = 0;
    edges(4);
    check("R8 stays clear", 4'b0000);
  endtask

  initial begin
    t_reset();
    t_read();
    t_early_ack();
    t_write();
    t_both();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule